// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Layered Write Protection

This block is the slave side of a two-wire serial memory. It sits on a shared bus with a clock line and an open-drain data line, and holds 256 bytes of storage that keep their contents and their protection state through the block's reset. A bus master addresses it with a device byte. Byte and page writes, and random, current-address and sequential reads, go through an internal address pointer. All bus lines are sampled with the system clock. The block drives the data line only by pulling it low through `sda_oe`.

Writes are filtered by two independent guards. A level on the `wp` pin protects the whole array while it is high. A one-time lock command permanently protects the lower half (word addresses 0x00 to 0x7F). The lock has its own device code, and the master can ask for its status. Bytes that land on protected locations are still acknowledged but are not stored. When a write transaction has stored at least one byte, or has set the lock, it starts a timed internal write cycle once the transaction ends. During that cycle the block answers no device byte, so the master can poll until the cycle is over.

Top module: `eep_slave`

## Requirements
- R1: The block acknowledges only a device byte whose upper four bits equal the memory code (default 4'b1010) or the lock code (default 4'b0110), whose bits 3..1 equal `addr_pins[2:0]`, and whose bit 0 is R/W (1 = read). Any other device byte gets no acknowledge, and the block stays silent until the next start.
- R2: A write of a word address, a repeated start and a read return the stored byte at that address. Further acknowledged reads advance the pointer by one, wrapping from 0xFF to 0x00.
- R3: A page write accepts 1 to 16 data bytes after the word address. The low 4 bits of the address advance and wrap inside the 16-byte page, and the upper 4 bits stay fixed.
- R4: While `wp` is high, no location changes, whether or not the lock is set. The data bytes are still acknowledged.
- R5: A write transaction to the lock code that carries at least one byte after the device byte sets the lock when it ends. After that, writes to 0x00..0x7F are rejected, while 0x80..0xFF stay writable. The lock survives `rst_n`.
- R6: A read device byte with the lock code is acknowledged while the lock is clear and not acknowledged once it is set.
- R7: After a stop that ends a write transaction which stored a byte, the block acknowledges no device byte for WCYCLE_CLKS clock cycles, and afterwards acknowledges again.
- R8: A write transaction that stores no byte (every byte protected, or only a word address sent) starts no internal write cycle.
- R9: After reset the data line is released (`sda_oe` low).
- R10: The block changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset of the bus logic and write timer |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_pins | input | 3 | Strap pins matched against device byte bits 3..1 |
| wp | input | 1 | High protects every location against writes |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except to make start and stop conditions. They also assume that SCL phases last several system clocks, so that the synchronised edges are seen in order, and that `wp` changes only between transactions. The bench drives the bus through tasks that hold each SCL phase for ten clocks and move SDA at the middle of the low phase. It issues starts and stops only when the slave has released the line, and it toggles `wp` only while the bus is idle. Random page writes, with random start offsets and lengths, run alongside directed cases: pointer wrap, protection of each half, lock status and acknowledge polling.

// File: rtl/eep_pkg.sv
// Package: shared types for the two-wire EEPROM slave.
// Assumes: nothing beyond IEEE 1800-2017.
package eep_pkg;

    // Protocol state of the bus link.
    typedef enum logic [2:0] {
        L_IDLE,   // waiting for a start condition
        L_ADDR,   // shifting in the device byte
        L_AACK,   // driving the acknowledge of the device byte
        L_WADDR,  // shifting in the word address
        L_WDATA,  // shifting in a data byte
        L_WACK,   // driving the acknowledge of a received byte
        L_RD,     // shifting out a read byte
        L_RACK    // sampling the master's acknowledge
    } link_state_t;

endpackage

// File: rtl/eep_sync.sv
// Module: eep_sync
// Brings SCL and SDA into the clock domain and detects SCL edges and
// start / stop conditions.
// Assumes: each SCL phase lasts at least four clock cycles.
module eep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_q, scl_d;
    logic sda_m, sda_q, sda_d;

    // Two-stage synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_q <= 1'b1;
            scl_d <= 1'b1;
            sda_m <= 1'b1;
            sda_q <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_m <= scl_i;
            scl_q <= scl_m;
            scl_d <= scl_q;
            sda_m <= sda_i;
            sda_q <= sda_m;
            sda_d <= sda_q;
        end
    end

    // Edge and bus-condition decode from the synchronised samples.
    always_comb begin
        scl_s     = scl_q;
        sda_s     = sda_q;
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
    end

endmodule

// File: rtl/eep_array.sv
// Module: eep_array
// Byte-wide storage with one write port and an asynchronous read port.
// Assumes: contents are nonvolatile, so they come up erased (all ones) at
// power-up and are not touched by the block reset.
module eep_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH] = '{default: 8'hFF};

    // Store one byte when the guard lets a write through.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Read the byte under the pointer.
    always_comb begin
        rdata = cells[raddr];
    end

endmodule

// File: rtl/eep_guard.sv
// Module: eep_guard
// Write policy, the permanent lower-half lock and the internal write-cycle
// timer.
// Assumes: lock_go and cycle_go are single-cycle pulses. The lock bit is
// nonvolatile: it powers up clear and rst_n never clears it.
module eep_guard #(
    parameter int ADDR_W      = 8,
    parameter int WCYCLE_CLKS = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              lock_go,
    input  logic              cycle_go,
    output logic              wr_ok,
    output logic              arr_we,
    output logic              locked,
    output logic              busy
);

    localparam int CNT_W = $clog2(WCYCLE_CLKS + 1);

    logic             lock_q = 1'b0;
    logic [CNT_W-1:0] cyc_cnt;

    // One-way lock: once set it stays set.
    always_ff @(posedge clk) begin
        if (lock_go) begin
            lock_q <= 1'b1;
        end
    end

    // Internal write cycle: load on a commit, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt <= '0;
        end else if (lock_go || cycle_go) begin
            cyc_cnt <= CNT_W'(WCYCLE_CLKS);
        end else if (cyc_cnt != '0) begin
            cyc_cnt <= cyc_cnt - 1'b1;
        end
    end

    // Protection policy: the pin covers everything, the lock the lower half.
    always_comb begin
        locked = lock_q;
        busy   = (cyc_cnt != '0);
        wr_ok  = ~wp & ~(lock_q & ~wr_addr[ADDR_W-1]);
        arr_we = wr_req & wr_ok;
    end

endmodule

// File: rtl/eep_link.sv
// Module: eep_link
// Bit-level protocol engine: device-byte match, word-address pointer,
// page-wrapped writes, sequential reads, lock command and query.
// Assumes: inputs come from eep_sync; rd_data shows the byte at ptr in the
// same cycle.
module eep_link
    import eep_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAGE_W    = 4,
    parameter logic [3:0]  TYPE_MEM  = 4'b1010,
    parameter logic [3:0]  TYPE_LOCK = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        pins,
    input  logic              busy,
    input  logic              locked,
    input  logic              wr_ok,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              lock_go,
    output logic              cycle_go
);

    localparam int HI_W = ADDR_W - PAGE_W;

    link_state_t st;
    logic [7:0]  shreg;
    logic [7:0]  tx;
    logic [3:0]  bcnt;
    logic        rw;
    logic        lock_txn;
    logic        wtxn;
    logic        stored_any;
    logic        got_byte;
    logic        mack;
    logic        hit_mem;
    logic        hit_lock;
    logic        addr_ack;
    logic        byte_in;
    logic [ADDR_W-1:0] ptr_page_next;

    // Device-byte decode and page-wrapped pointer advance.
    always_comb begin
        hit_mem       = (shreg[7:4] == TYPE_MEM)  && (shreg[3:1] == pins);
        hit_lock      = (shreg[7:4] == TYPE_LOCK) && (shreg[3:1] == pins);
        addr_ack      = ~busy & (hit_mem | (hit_lock & ~locked));
        byte_in       = scl_fall && (bcnt == 4'd8);
        ptr_page_next = {ptr[ADDR_W-1 -: HI_W], ptr[PAGE_W-1:0] + 1'b1};
    end

    // Protocol state machine, bit shifting and transaction bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= L_IDLE;
            shreg      <= '0;
            tx         <= '0;
            bcnt       <= '0;
            rw         <= 1'b0;
            lock_txn   <= 1'b0;
            wtxn       <= 1'b0;
            stored_any <= 1'b0;
            got_byte   <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            wr_req     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            ptr        <= '0;
            lock_go    <= 1'b0;
            cycle_go   <= 1'b0;
        end else begin
            wr_req   <= 1'b0;
            lock_go  <= 1'b0;
            cycle_go <= 1'b0;
            if (wr_req && wr_ok) begin
                stored_any <= 1'b1;
            end
            if (start_det || stop_det) begin
                // A start or stop closes any open write transaction.
                cycle_go   <= wtxn & ~lock_txn & stored_any;
                lock_go    <= wtxn & lock_txn & got_byte;
                wtxn       <= 1'b0;
                stored_any <= 1'b0;
                got_byte   <= 1'b0;
                sda_oe     <= 1'b0;
                bcnt       <= '0;
                st         <= start_det ? L_ADDR : L_IDLE;
            end else begin
                unique case (st)
                    L_ADDR, L_WADDR, L_WDATA: begin
                        if (scl_rise && bcnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            bcnt  <= bcnt + 1'b1;
                        end
                        if (byte_in) begin
                            bcnt <= '0;
                            if (st == L_ADDR) begin
                                if (addr_ack) begin
                                    sda_oe   <= 1'b1;
                                    rw       <= shreg[0];
                                    lock_txn <= hit_lock;
                                    wtxn     <= ~shreg[0];
                                    st       <= L_AACK;
                                end else begin
                                    st <= L_IDLE;
                                end
                            end else begin
                                if (!lock_txn) begin
                                    if (st == L_WADDR) begin
                                        ptr <= shreg;
                                    end else begin
                                        wr_req  <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr_page_next;
                                    end
                                end
                                got_byte <= 1'b1;
                                sda_oe   <= 1'b1;
                                st       <= L_WACK;
                            end
                        end
                    end
                    L_AACK: begin
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (!rw) begin
                                sda_oe <= 1'b0;
                                st     <= L_WADDR;
                            end else if (lock_txn) begin
                                sda_oe <= 1'b0;
                                st     <= L_IDLE;
                            end else begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 1'b1;
                                st     <= L_RD;
                            end
                        end
                    end
                    L_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bcnt   <= '0;
                            st     <= L_WDATA;
                        end
                    end
                    L_RD: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 1'b1;
                        end
                        if (byte_in) begin
                            sda_oe <= 1'b0;
                            st     <= L_RACK;
                        end else if (scl_fall) begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                    L_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (mack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 1'b1;
                                st     <= L_RD;
                            end else begin
                                st <= L_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_slave.sv
// Module: eep_slave (top)
// Two-wire serial EEPROM slave: 256 bytes, 16-byte pages, pin write protect
// over the whole array, permanent lock over the lower half, and a timed
// internal write cycle during which the device byte is not acknowledged.
// Assumes: SCL phases span several clock cycles; sda_i is the wired-AND bus.
module eep_slave #(
    parameter int         WCYCLE_CLKS = 5000,
    parameter logic [3:0] TYPE_MEM    = 4'b1010,
    parameter logic [3:0] TYPE_LOCK   = 4'b0110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] addr_pins,
    input  logic       wp
);

    localparam int ADDR_W = 8;
    localparam int PAGE_W = 4;

    logic              scl_s, sda_s, scl_rise, scl_fall;
    logic              start_det, stop_det, end_det;
    logic              busy, locked, wr_ok, arr_we;
    logic              wr_req, lock_go, cycle_go;
    logic [ADDR_W-1:0] wr_addr, ptr;
    logic [7:0]        wr_data, rd_data;

    // Either bus condition ends a transaction.
    always_comb begin
        end_det = start_det | stop_det;
    end

    eep_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_link #(
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W),
        .TYPE_MEM  (TYPE_MEM),
        .TYPE_LOCK (TYPE_LOCK)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .pins      (addr_pins),
        .busy      (busy),
        .locked    (locked),
        .wr_ok     (wr_ok),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .lock_go   (lock_go),
        .cycle_go  (cycle_go)
    );

    eep_guard #(
        .ADDR_W      (ADDR_W),
        .WCYCLE_CLKS (WCYCLE_CLKS)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .wp       (wp),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .lock_go  (lock_go),
        .cycle_go (cycle_go),
        .wr_ok    (wr_ok),
        .arr_we   (arr_we),
        .locked   (locked),
        .busy     (busy)
    );

    eep_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/eep_slave_chk.sv
// Module: eep_slave_chk
// Property checker bound into eep_slave.
// Assumes: the master obeys the bus rules (SDA moves only while SCL is low,
// apart from start and stop) and wp changes only between transactions.
module eep_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       end_det,
    input logic       busy,
    input logic       locked,
    input logic       arr_we,
    input logic       wr_req,
    input logic [7:0] wr_addr,
    input logic [7:0] ptr
);

    // R4: nothing reaches the array while the pin protects it.
    a_r4_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !wp);

    // R5: with the lock set, only upper-half writes reach the array.
    a_r5_lower_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && locked) |-> wr_addr[7]);

    // R5: the lock never clears.
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R3: a page write keeps the pointer inside the page of the write.
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (ptr[7:4] == wr_addr[7:4]));

    // R7: the internal write cycle starts only two cycles after a start or stop.
    a_r7_cycle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(end_det, 2));

    // R10: the data drive moves only while the synchronised SCL is low.
    a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

endmodule

bind eep_slave eep_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp      (wp),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe),
    .end_det (end_det),
    .busy    (busy),
    .locked  (locked),
    .arr_we  (arr_we),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .ptr     (ptr)
);

// File: tb/eep_slave_test.sv
// Bench for eep_slave: a task-level bus master, a byte model of the array
// and the lock, random page writes from a fixed seed, and directed corners.
module eep_slave_test;

    localparam int         WC     = 300;
    localparam logic [2:0] PINS   = 3'b101;
    localparam logic [3:0] C_MEM  = 4'b1010;
    localparam logic [3:0] C_LOCK = 4'b0110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       sda_oe;
    logic       sda_bus;
    logic [2:0] pins = PINS;

    int errors = 0;
    int checks = 0;
    int r10_viol = 0;

    logic [7:0] exp_mem [256];
    logic       exp_lock = 1'b0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [20];

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    eep_slave #(.WCYCLE_CLKS(WC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .addr_pins (pins),
        .wp        (wp)
    );

    // Record any change of the data drive while SCL is high (R10).
    logic scl_prev = 1'b1, oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe != oe_prev)) r10_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    function automatic logic may_store(input logic [7:0] a);
        return !wp && !(exp_lock && !a[7]);
    endfunction

    function automatic logic [7:0] page_addr(input logic [7:0] base, input int i);
        return {base[7:4], 4'(base[3:0] + i)};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (scl_m) begin
            sda_m = 1'b0; tick(5); scl_m = 1'b0;
        end else begin
            tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1;
            tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0;
        end
    endtask

    task automatic bus_stop();
        tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(5); sda_m = b[i]; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0;
        end
        tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
        ack = !sda_bus;
        tick(5); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(10); scl_m = 1'b1; tick(5); b[i] = sda_bus; tick(5); scl_m = 1'b0;
        end
        tick(5); sda_m = !give_ack; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0;
        tick(5); sda_m = 1'b1;
    endtask

    // Device byte only, then stop; returns the acknowledge.
    task automatic probe(input logic [3:0] code, input logic [2:0] p, input logic rd, output logic ack);
        bus_start();
        send_byte({code, p, rd}, ack);
        bus_stop();
    endtask

    // Poll with the memory code until acknowledged; returns the poll count.
    task automatic poll_ready(output int tries);
        logic ack;
        tries = 0;
        for (int k = 0; k < 12; k++) begin
            probe(C_MEM, PINS, 1'b0, ack);
            tries++;
            if (ack) break;
        end
    endtask

    // Page write of n bytes from wbuf; the model follows the requirements.
    task automatic mem_write(input logic [7:0] a, input int n, output logic all_ack);
        logic ack;
        bus_start();
        send_byte({C_MEM, PINS, 1'b0}, ack); all_ack = ack;
        send_byte(a, ack); all_ack &= ack;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); all_ack &= ack;
            if (may_store(page_addr(a, i))) exp_mem[page_addr(a, i)] = wbuf[i];
        end
        bus_stop();
    endtask

    // Random read of n bytes into rbuf.
    task automatic mem_read(input logic [7:0] a, input int n, output logic all_ack);
        logic ack;
        bus_start();
        send_byte({C_MEM, PINS, 1'b0}, ack); all_ack = ack;
        send_byte(a, ack); all_ack &= ack;
        bus_start();
        send_byte({C_MEM, PINS, 1'b1}, ack); all_ack &= ack;
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic verify_read(input logic [7:0] a, input int n, input string req);
        logic ok;
        mem_read(a, n, ok);
        check(ok, {req, " read acks"}, ok, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ad = 8'(a + i);
            check(rbuf[i] == exp_mem[ad], req, rbuf[i], exp_mem[ad]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ack, ok;
        int   tries, n;
        logic [7:0] a;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;

        tick(4);
        // R9: line released during and after reset.
        check(sda_oe == 1'b0, "R9 released in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(4);
        check(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);

        // R1: wrong strap bits, wrong code, right address.
        probe(C_MEM, 3'b100, 1'b0, ack);
        check(!ack, "R1 pin mismatch no ack", ack, 0);
        probe(4'b1011, PINS, 1'b0, ack);
        check(!ack, "R1 code mismatch no ack", ack, 0);
        probe(C_MEM, PINS, 1'b1, ack);
        check(ack, "R1 match ack", ack, 1);

        // R7: single byte write, then busy polling.
        wbuf[0] = 8'h5A;
        mem_write(8'h23, 1, ok);
        check(ok, "R7 byte write acks", ok, 1);
        poll_ready(tries);
        check(tries >= 2 && tries <= 4, "R7 busy then ready", tries, 2);

        // R2: random read of the byte just written.
        verify_read(8'h23, 1, "R2 random read");

        // R3: partial page write wrapping inside the page.
        for (int i = 0; i < 6; i++) wbuf[i] = 8'($urandom);
        mem_write(8'h3C, 6, ok);
        check(ok, "R3 page write acks", ok, 1);
        poll_ready(tries);
        verify_read(8'h30, 16, "R3 page wrap");

        // R2: sequential read across 0xFF to 0x00.
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        mem_write(8'hFF, 1, ok); poll_ready(tries);
        mem_write(8'h00, 1, ok); poll_ready(tries);
        wbuf[0] = 8'h96;
        mem_write(8'h01, 1, ok); poll_ready(tries);
        verify_read(8'hFE, 4, "R2 pointer wrap");

        // R3: random page writes of random length and offset.
        for (int it = 0; it < 5; it++) begin
            a = 8'($urandom);
            n = 1 + int'($urandom % 16);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            mem_write(a, n, ok);
            check(ok, "R3 random write acks", ok, 1);
            poll_ready(tries);
            verify_read({a[7:4], 4'h0}, 16, "R3 random page");
        end

        // R8: word address only starts no cycle.
        bus_start(); send_byte({C_MEM, PINS, 1'b0}, ack); send_byte(8'h44, ack); bus_stop();
        probe(C_MEM, PINS, 1'b0, ack);
        check(ack, "R8 address-only no busy", ack, 1);

        // R4 and R8: pin protection, bytes acked, nothing stored, no cycle.
        wp = 1'b1;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        mem_write(8'h90, 2, ok);
        check(ok, "R4 protected bytes acked", ok, 1);
        probe(C_MEM, PINS, 1'b0, ack);
        check(ack, "R8 protected write no busy", ack, 1);
        wp = 1'b0;
        verify_read(8'h90, 2, "R4 pin protect");

        // R6: status while clear.
        probe(C_LOCK, PINS, 1'b1, ack);
        check(ack, "R6 query unlocked ack", ack, 1);

        // R5: lock command.
        bus_start();
        send_byte({C_LOCK, PINS, 1'b0}, ack);
        check(ack, "R5 lock command acked", ack, 1);
        send_byte(8'h00, ack); send_byte(8'h00, ack);
        bus_stop();
        exp_lock = 1'b1;
        poll_ready(tries);
        probe(C_LOCK, PINS, 1'b1, ack);
        check(!ack, "R6 query locked no ack", ack, 0);

        wbuf[0] = 8'hA5;
        mem_write(8'h10, 1, ok);
        check(ok, "R5 lower write acked", ok, 1);
        probe(C_MEM, PINS, 1'b0, ack);
        check(ack, "R8 lower write no busy", ack, 1);
        verify_read(8'h10, 1, "R5 lower half locked");
        wbuf[0] = 8'h7E;
        mem_write(8'hC4, 1, ok);
        poll_ready(tries);
        verify_read(8'hC4, 1, "R5 upper half writable");

        // R5: lock survives the block reset.
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        probe(C_LOCK, PINS, 1'b1, ack);
        check(!ack, "R5 lock after reset", ack, 0);

        // R4: pin plus lock protects the upper half too.
        wp = 1'b1;
        wbuf[0] = 8'h01;
        mem_write(8'hC4, 1, ok);
        wp = 1'b0;
        verify_read(8'hC4, 1, "R4 pin with lock");

        // R10: no data drive change seen while SCL high.
        check(r10_viol == 0, "R10 drive only with SCL low", r10_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule